// File: doc/BRIEF.md
# Independent Watchdog and Clock Monitor

This supervisory block runs on a reference clock that is separate from the processor clock it watches. It performs three checks. Software must send a service strobe inside a programmable window. Interrupt code must send at least one heartbeat strobe in every monitoring window. The processor clock frequency must stay between two programmable bounds. The frequency is measured against the reference clock.

Both strobes start in the processor clock domain. Each strobe becomes a toggle, passes through a flop synchronizer and goes through edge detection before the reference domain uses it. The processor clock is divided down and carried across the same way. Its edges are counted over a fixed window of reference cycles.

The first failure found is kept as a fault code until reset. The same event drives a dedicated alarm pin, so an LED or beeper can signal the failure without any action from the processor. The configuration inputs are copied into registers while the monitor is idle. They are frozen once the monitor has been enabled.

The block has no data stream, so it has no valid/ready interface. All of its pins are plain control and status signals.

Top module: `indep_supervisor`

## Requirements
- R1: After reset, `fault_code_o` is 0 and `alarm_o` is 0.
- R2: While `enable_i` has not yet been seen high, no fault is raised, however the strobes and the clock behave. After `enable_i` is seen high, the monitor stays enabled until reset.
- R3: If no service strobe is recognised for `cfg_svc_limit_i` reference cycles after enable or after the last valid service, the fault code becomes 1 (late service).
- R4: A service strobe recognised less than `cfg_svc_open_i` reference cycles after enable or after the last valid service sets the fault code to 2 (early service).
- R5: A monitoring window of `cfg_irq_window_i` reference cycles that ends with no heartbeat recognised sets the fault code to 3 (interrupt missing). Windows run back to back from enable.
- R6: Over every `MEAS_WIN` reference cycles, the block counts one edge per 2^`DIV_W` processor cycles. A count above `cfg_freq_hi_i` sets the fault code to 4 (clock fast).
- R7: A nonzero count below `cfg_freq_lo_i` sets the fault code to 5 (clock slow).
- R8: A count of zero sets the fault code to 6 (clock absent).
- R9: `alarm_o` is 1 exactly when `fault_code_o` is nonzero. Both change on the same reference edge.
- R10: A fault code, once set, holds until reset, and later failures do not change it. If several failures appear on the same cycle, the higher code is kept.
- R11: The configuration values are captured on the edge where `enable_i` is first seen high. Later changes on the configuration inputs have no effect.
- R12: A strobe held high for one processor clock cycle is recognised exactly once in the reference domain. Strobes inside the service window therefore keep the monitor quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Independent reference clock; all timing logic runs on it |
| cpu_clk | input | 1 | Supervised processor clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| enable_i | input | 1 | Starts supervision (sticky until reset) |
| svc_strobe_i | input | 1 | Service strobe, processor domain |
| irq_beat_i | input | 1 | Interrupt heartbeat strobe, processor domain |
| cfg_svc_open_i | input | TW | Earliest allowed service, reference cycles |
| cfg_svc_limit_i | input | TW | Service timeout, reference cycles |
| cfg_irq_window_i | input | TW | Heartbeat window, reference cycles |
| cfg_freq_lo_i | input | CW | Lowest acceptable edge count per window |
| cfg_freq_hi_i | input | CW | Highest acceptable edge count per window |
| fault_code_o | output | 3 | Latched fault: 0 none, 1 late, 2 early, 3 irq, 4 fast, 5 slow, 6 absent |
| alarm_o | output | 1 | Direct alarm drive |

## Verification
The bench builds the block with TW=12, CW=8, MEAS_WIN=64 and DIV_W=1, so each counted edge stands for two processor cycles. With these values, processor clock periods of 8 ns, 24 ns and 100 ns give counts of about 40, 13 and 3 against bounds of 8 and 18. Stopping the processor clock gives a count of zero. The short service and heartbeat windows (20 to 200 and 150 cycles) let each timeout be reached in a few hundred reference cycles. The bench can therefore check when a fault appears, not only which fault appears.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_SVC_LATE  = 3'd1,
    FLT_SVC_EARLY = 3'd2,
    FLT_IRQ_MISS  = 3'd3,
    FLT_CLK_FAST  = 3'd4,
    FLT_CLK_SLOW  = 3'd5,
    FLT_CLK_DEAD  = 3'd6
  } fault_e;
endpackage

// File: rtl/sup_strobe_sync.sv
// Turns a source-domain strobe into a toggle, synchronizes the toggle into
// the destination domain and emits a one-cycle pulse per change.
module sup_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic src_clk,
  input  logic dst_clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic pulse_o
);
  logic              src_tgl;
  logic [STAGES:0]   chain_q;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n)        src_tgl <= 1'b0;
    else if (strobe_i) src_tgl <= ~src_tgl;
  end

  // chain_q[STAGES-1:0] are the synchronizer stages, chain_q[STAGES] keeps history
  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-1:0], src_tgl};
  end

  assign pulse_o = chain_q[STAGES] ^ chain_q[STAGES-1];
endmodule

// File: rtl/sup_freq_meter.sv
module sup_freq_meter #(
  parameter int WIN         = 64,
  parameter int CW          = 8,
  parameter int DIV_W       = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic          cpu_clk,
  input  logic          ref_clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [CW-1:0] lo_i,
  input  logic [CW-1:0] hi_i,
  output logic          fast_o,
  output logic          slow_o,
  output logic          dead_o
);
  localparam int WW = (WIN > 2) ? $clog2(WIN) : 1;

  logic [DIV_W-1:0] div_q;
  logic             tick;
  logic             edge_p;
  logic [WW-1:0]    win_q;
  logic [CW-1:0]    cnt_q;
  logic [CW:0]      total;
  logic             win_end;

  always_ff @(posedge cpu_clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  assign tick = &div_q;

  sup_strobe_sync #(.STAGES(SYNC_STAGES)) u_clk_sync (
    .src_clk  (cpu_clk),
    .dst_clk  (ref_clk),
    .rst_n    (rst_n),
    .strobe_i (tick),
    .pulse_o  (edge_p)
  );

  assign total   = {1'b0, cnt_q} + {{CW{1'b0}}, edge_p};
  assign win_end = (win_q == WW'(WIN - 1));

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      cnt_q  <= '0;
      fast_o <= 1'b0;
      slow_o <= 1'b0;
      dead_o <= 1'b0;
    end else if (!run_i) begin
      win_q  <= '0;
      cnt_q  <= '0;
      fast_o <= 1'b0;
      slow_o <= 1'b0;
      dead_o <= 1'b0;
    end else begin
      fast_o <= 1'b0;
      slow_o <= 1'b0;
      dead_o <= 1'b0;
      if (win_end) begin
        win_q  <= '0;
        cnt_q  <= '0;
        dead_o <= (total == '0);
        fast_o <= (total > {1'b0, hi_i});
        slow_o <= (total != '0) && (total < {1'b0, lo_i});
      end else begin
        win_q <= win_q + 1'b1;
        if (edge_p && !(&cnt_q)) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_one_verdict_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $onehot0({fast_o, slow_o, dead_o}));
  assert_window_bound_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    win_q <= WW'(WIN - 1));
endmodule

// File: rtl/sup_svc_timer.sv
module sup_svc_timer #(
  parameter int TW = 16
) (
  input  logic          ref_clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          pulse_i,
  input  logic [TW-1:0] open_i,
  input  logic [TW-1:0] limit_i,
  output logic          late_o,
  output logic          early_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)                               cnt_q <= '0;
    else if (!run_i)                          cnt_q <= '0;
    else if (pulse_i && (cnt_q >= open_i))    cnt_q <= '0;
    else if (!pulse_i && (cnt_q < limit_i))   cnt_q <= cnt_q + 1'b1;
  end

  assign late_o  = run_i && !pulse_i && (cnt_q >= limit_i);
  assign early_o = run_i &&  pulse_i && (cnt_q <  open_i);

  assert_cnt_capped_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    run_i |=> (cnt_q <= limit_i));
endmodule

// File: rtl/sup_beat_window.sv
module sup_beat_window #(
  parameter int TW = 16
) (
  input  logic          ref_clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          pulse_i,
  input  logic [TW-1:0] window_i,
  output logic          miss_o
);
  logic [TW-1:0] cnt_q;
  logic          seen_q;
  logic          last;

  assign last   = ({1'b0, cnt_q} + 1'b1) >= {1'b0, window_i};
  assign miss_o = run_i && last && !(seen_q || pulse_i);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (last) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      seen_q <= seen_q || pulse_i;
    end
  end

  assert_cnt_in_window_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (run_i && (window_i != '0)) |-> (cnt_q < window_i));
endmodule

// File: rtl/indep_supervisor.sv
module indep_supervisor
  import sup_pkg::*;
#(
  parameter int TW          = 16,
  parameter int CW          = 8,
  parameter int MEAS_WIN    = 64,
  parameter int DIV_W       = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic          ref_clk,
  input  logic          cpu_clk,
  input  logic          rst_n,
  input  logic          enable_i,
  input  logic          svc_strobe_i,
  input  logic          irq_beat_i,
  input  logic [TW-1:0] cfg_svc_open_i,
  input  logic [TW-1:0] cfg_svc_limit_i,
  input  logic [TW-1:0] cfg_irq_window_i,
  input  logic [CW-1:0] cfg_freq_lo_i,
  input  logic [CW-1:0] cfg_freq_hi_i,
  output logic [2:0]    fault_code_o,
  output logic          alarm_o
);
  localparam int NSTROBE = 2;

  logic          en_q;
  logic [TW-1:0] open_q, limit_q, window_q;
  logic [CW-1:0] lo_q, hi_q;
  fault_e        fault_q;
  logic          alarm_q;

  logic [NSTROBE-1:0] strobe_vec, pulse_vec;
  logic late, early, miss, fast, slow, dead;

  // Enable is sticky; configuration shadows the inputs until enabled, then freezes
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      open_q   <= '0;
      limit_q  <= '0;
      window_q <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
    end else begin
      if (enable_i) en_q <= 1'b1;
      if (!en_q) begin
        open_q   <= cfg_svc_open_i;
        limit_q  <= cfg_svc_limit_i;
        window_q <= cfg_irq_window_i;
        lo_q     <= cfg_freq_lo_i;
        hi_q     <= cfg_freq_hi_i;
      end
    end
  end

  assign strobe_vec = {irq_beat_i, svc_strobe_i};

  for (genvar g = 0; g < NSTROBE; g++) begin : g_strobe
    sup_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .src_clk  (cpu_clk),
      .dst_clk  (ref_clk),
      .rst_n    (rst_n),
      .strobe_i (strobe_vec[g]),
      .pulse_o  (pulse_vec[g])
    );
  end

  sup_svc_timer #(.TW(TW)) u_svc (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .run_i   (en_q),
    .pulse_i (pulse_vec[0]),
    .open_i  (open_q),
    .limit_i (limit_q),
    .late_o  (late),
    .early_o (early)
  );

  sup_beat_window #(.TW(TW)) u_beat (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .run_i    (en_q),
    .pulse_i  (pulse_vec[1]),
    .window_i (window_q),
    .miss_o   (miss)
  );

  sup_freq_meter #(
    .WIN(MEAS_WIN), .CW(CW), .DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_freq (
    .cpu_clk (cpu_clk),
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .run_i   (en_q),
    .lo_i    (lo_q),
    .hi_i    (hi_q),
    .fast_o  (fast),
    .slow_o  (slow),
    .dead_o  (dead)
  );

  // First failure wins; on a tie the higher code is kept
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= FLT_NONE;
      alarm_q <= 1'b0;
    end else if (en_q && (fault_q == FLT_NONE)) begin
      if (late || early || miss || fast || slow || dead) alarm_q <= 1'b1;
      if      (dead)  fault_q <= FLT_CLK_DEAD;
      else if (slow)  fault_q <= FLT_CLK_SLOW;
      else if (fast)  fault_q <= FLT_CLK_FAST;
      else if (miss)  fault_q <= FLT_IRQ_MISS;
      else if (early) fault_q <= FLT_SVC_EARLY;
      else if (late)  fault_q <= FLT_SVC_LATE;
    end
  end

  assign fault_code_o = fault_q;
  assign alarm_o      = alarm_q;

  assert_fault_sticky_R10: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (fault_q != FLT_NONE) |=> $stable(fault_q));
  assert_cfg_locked_R11: assert property (@(posedge ref_clk) disable iff (!rst_n)
    en_q |=> ($stable(limit_q) && $stable(open_q) && $stable(window_q)
              && $stable(lo_q) && $stable(hi_q)));
  assert_idle_quiet_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !en_q |-> (fault_q == FLT_NONE));
  assert_alarm_tracks_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    alarm_q == (fault_q != FLT_NONE));
  assert_enable_sticky_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    en_q |=> en_q);
endmodule

// File: tb/test_indep_supervisor.sv
`timescale 1ns/1ps
module test_indep_supervisor;
  localparam int TW = 12;
  localparam int CW = 8;

  logic          ref_clk = 1'b0;
  logic          cpu_clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable_i = 1'b0;
  logic          svc_strobe_i = 1'b0;
  logic          irq_beat_i = 1'b0;
  logic [TW-1:0] cfg_svc_open_i = 12'd20;
  logic [TW-1:0] cfg_svc_limit_i = 12'd200;
  logic [TW-1:0] cfg_irq_window_i = 12'd150;
  logic [CW-1:0] cfg_freq_lo_i = 8'd8;
  logic [CW-1:0] cfg_freq_hi_i = 8'd18;
  logic [2:0]    fault_code_o;
  logic          alarm_o;

  real cpu_half = 12.0;
  bit  cpu_run  = 1'b1;
  bit  svc_on   = 1'b0;
  bit  irq_on   = 1'b0;
  int  svc_gap  = 100;
  int  irq_gap  = 50;
  int  checks   = 0;
  int  errors   = 0;
  logic [2:0] exp_q[$];
  logic prev_alarm = 1'b0;

  indep_supervisor #(.TW(TW), .CW(CW), .MEAS_WIN(64), .DIV_W(1)) i_indep_supervisor (
    .ref_clk          (ref_clk),
    .cpu_clk          (cpu_clk),
    .rst_n            (rst_n),
    .enable_i         (enable_i),
    .svc_strobe_i     (svc_strobe_i),
    .irq_beat_i       (irq_beat_i),
    .cfg_svc_open_i   (cfg_svc_open_i),
    .cfg_svc_limit_i  (cfg_svc_limit_i),
    .cfg_irq_window_i (cfg_irq_window_i),
    .cfg_freq_lo_i    (cfg_freq_lo_i),
    .cfg_freq_hi_i    (cfg_freq_hi_i),
    .fault_code_o     (fault_code_o),
    .alarm_o          (alarm_o)
  );

  always #5 ref_clk = ~ref_clk;

  initial begin
    forever begin
      if (cpu_run) #(cpu_half) cpu_clk = ~cpu_clk;
      else         #(5.0);
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Service and heartbeat generators (processor domain strobes, one cpu cycle)
  initial begin
    forever begin
      if (svc_on) begin
        repeat (svc_gap) @(posedge ref_clk);
        @(negedge cpu_clk) svc_strobe_i = 1'b1;
        @(negedge cpu_clk) svc_strobe_i = 1'b0;
      end else @(posedge ref_clk);
    end
  end

  initial begin
    forever begin
      if (irq_on) begin
        repeat (irq_gap) @(posedge ref_clk);
        @(negedge cpu_clk) irq_beat_i = 1'b1;
        @(negedge cpu_clk) irq_beat_i = 1'b0;
      end else @(posedge ref_clk);
    end
  end

  // Scoreboard monitor: each rising alarm consumes one expected code
  initial begin
    forever begin
      @(negedge ref_clk);
      if (rst_n && alarm_o && !prev_alarm) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected alarm", int'(fault_code_o), 0);
        end else begin
          automatic logic [2:0] e = exp_q.pop_front();
          check(fault_code_o == e, "R9 alarm code", int'(fault_code_o), int'(e));
        end
      end
      prev_alarm = alarm_o;
    end
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  task automatic quiesce();
    svc_on = 1'b0;
    irq_on = 1'b0;
    repeat (150) @(posedge ref_clk);
  endtask

  task automatic do_reset();
    @(negedge ref_clk);
    rst_n = 1'b0;
    enable_i = 1'b0;
    cfg_svc_open_i = 12'd20;
    cfg_svc_limit_i = 12'd200;
    cfg_irq_window_i = 12'd150;
    cfg_freq_lo_i = 8'd8;
    cfg_freq_hi_i = 8'd18;
    exp_q.delete();
    repeat (4) @(negedge ref_clk);
    rst_n = 1'b1;
    @(negedge ref_clk);
  endtask

  task automatic start(bit s, bit i);
    svc_on = s;
    irq_on = i;
    enable_i = 1'b1;
    @(negedge ref_clk);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic expect_fault(logic [2:0] code, string req);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    check(fault_code_o == code, req, int'(fault_code_o), int'(code));
    check(alarm_o == 1'b1, req, int'(alarm_o), 1);
  endtask

  initial begin
    svc_gap = 100;
    irq_gap = 50;
    cpu_half = 12.0;

    // R1 reset state
    do_reset();
    check(fault_code_o == 3'd0, "R1 code after reset", int'(fault_code_o), 0);
    check(alarm_o == 1'b0, "R1 alarm after reset", int'(alarm_o), 0);

    // R2 idle: no strobes, not enabled, nothing happens
    wait_cyc(500);
    check(fault_code_o == 3'd0, "R2 idle code", int'(fault_code_o), 0);
    check(alarm_o == 1'b0, "R2 idle alarm", int'(alarm_o), 0);

    // R12 nominal operation stays quiet
    start(1'b1, 1'b1);
    enable_i = 1'b0;   // R2 enable is sticky
    wait_cyc(1000);
    check(fault_code_o == 3'd0, "R12 nominal code", int'(fault_code_o), 0);
    check(alarm_o == 1'b0, "R12 nominal alarm", int'(alarm_o), 0);

    // R11 configuration locked after enable
    quiesce();
    do_reset();
    start(1'b1, 1'b1);
    cfg_svc_limit_i = 12'd30;
    cfg_freq_hi_i = 8'd2;
    wait_cyc(800);
    check(alarm_o == 1'b0, "R11 cfg change ignored", int'(alarm_o), 0);

    // R3 late service
    quiesce();
    do_reset();
    exp_q.push_back(3'd1);
    start(1'b0, 1'b1);
    wait_cyc(189);
    check(alarm_o == 1'b0, "R3 not before limit", int'(alarm_o), 0);
    wait_cyc(20);
    expect_fault(3'd1, "R3 late service");

    // R1 reset clears a fault
    quiesce();
    do_reset();
    check(fault_code_o == 3'd0, "R1 reset clears code", int'(fault_code_o), 0);
    check(alarm_o == 1'b0, "R1 reset clears alarm", int'(alarm_o), 0);

    // R4 early service
    svc_gap = 8;
    exp_q.push_back(3'd2);
    start(1'b1, 1'b1);
    wait_cyc(40);
    expect_fault(3'd2, "R4 early service");
    svc_gap = 100;

    // R5 missing heartbeat
    quiesce();
    do_reset();
    exp_q.push_back(3'd3);
    start(1'b1, 1'b0);
    wait_cyc(139);
    check(alarm_o == 1'b0, "R5 not before window end", int'(alarm_o), 0);
    wait_cyc(20);
    expect_fault(3'd3, "R5 heartbeat missing");

    // R6 clock fast, then R10 stickiness
    quiesce();
    cpu_half = 4.0;
    do_reset();
    exp_q.push_back(3'd4);
    start(1'b1, 1'b1);
    wait_cyc(80);
    expect_fault(3'd4, "R6 clock fast");
    svc_on = 1'b0;
    irq_on = 1'b0;
    wait_cyc(400);
    check(fault_code_o == 3'd4, "R10 sticky code", int'(fault_code_o), 4);
    check(alarm_o == 1'b1, "R10 sticky alarm", int'(alarm_o), 1);

    // R7 clock slow
    quiesce();
    cpu_half = 50.0;
    do_reset();
    exp_q.push_back(3'd5);
    start(1'b1, 1'b1);
    wait_cyc(80);
    expect_fault(3'd5, "R7 clock slow");

    // R8 clock absent
    quiesce();
    cpu_run = 1'b0;
    do_reset();
    exp_q.push_back(3'd6);
    start(1'b0, 1'b0);
    wait_cyc(80);
    expect_fault(3'd6, "R8 clock absent");
    cpu_run = 1'b1;
    cpu_half = 12.0;

    wait_cyc(5);
    summary();
  end
endmodule